// File: doc/BRIEF.md
# Bitstream Third-Order Decimating Filter

This block turns the single-bit output of a second-order sigma-delta modulator into signed multi-bit samples at a lower rate. It applies a third-order FIR low-pass response, the cube of an N-tap boxcar. The decimation ratio N can be set at run time, up to a parameter maximum of 10000. The filter weights are not stored anywhere. Each of three accumulator lanes generates its own weight sequence from two running differences, updated once per accepted bit.

A modulator bit is taken on any clock edge where the valid strobe is high. Each lane integrates a window of 3·N bits. A bit of 1 adds the current weight and a bit of 0 subtracts it. The lanes are offset from each other by N bits, so one of them closes its window every N accepted bits. The closed result goes out as one sample pulse. A synchronous restart loads a new ratio and clears every window. The two samples that follow a restart come from lanes that never saw a full window, so they are marked as not settled.

Top module: `bitstream_sinc3_decim`

## Requirements
- R1: After reset, and in the cycle after a restart, `smp_valid` and `smp_settled` are 0 and `smp_out` is 0.
- R2: Each run of N accepted bits (`bit_vld`=1 while `restart`=0) produces exactly one `smp_valid` pulse. The pulse is high for the single cycle that follows the edge accepting the N-th bit, and no pulse appears at any other time.
- R3: A settled sample is the sum of s·h[k] over the last 3·N accepted bits. Here s is +1 for a 1 bit and -1 for a 0 bit, and k counts from 0 at the oldest bit. The weight h[k] is the number of triples (a,b,c), each in 0..N-1, with a+b+c = k, so h[3N-2] = h[3N-1] = 0. The case N=1 is included.
- R4: The first two samples after a restart carry `smp_settled`=0 and the value 0. Every later sample carries `smp_settled`=1.
- R5: Cycles with `bit_vld`=0 are ignored, whatever value `bit_in` has in them.
- R6: The ratio input is sampled only while `restart` is high. A change at any other time does not alter the sample spacing or the values.
- R7: A requested ratio of 0 is used as 1. A ratio above RATIO_MAX is used as RATIO_MAX.
- R8: Restart discards every open window. A bit presented in the same cycle as `restart` is not accepted, even when it would have completed a window.
- R9: At N = RATIO_MAX the accumulators never overflow. An all-ones stream settles to +N³ and an all-zeros stream to -N³.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| restart | input | 1 | Synchronous restart; loads the ratio and clears all windows |
| ratio | input | $clog2(RATIO_MAX+1) | Requested decimation ratio N |
| bit_in | input | 1 | Modulator output bit |
| bit_vld | input | 1 | Qualifies `bit_in` for this cycle |
| smp_out | output | 2+3·$clog2(RATIO_MAX) | Signed decimated sample |
| smp_valid | output | 1 | One-cycle pulse marking a new sample |
| smp_settled | output | 1 | Sample comes from a complete window |

## Verification
Two things coincide on the edge that accepts the N-th bit of a period. One lane finishes its window, which is output, while the same lane opens its next window at weight index 0. With N=1 this happens on every bit, and the bench streams bits back to back to force it. The bench also lets a restart arrive together with a bit that would have finished a window. The scoreboard model computes each expected sample from the bit history and the cubed-boxcar weights, and any pulse the model did not predict is reported as a mismatch.

// File: rtl/sinc3_pkg.sv
// Shared types and helpers for the bitstream decimator.
// Assumes: a window consists of three phases, each N bits long.
package sinc3_pkg;

    typedef enum logic [1:0] {
        PH_RISE = 2'd0,
        PH_TOP  = 2'd1,
        PH_FALL = 2'd2
    } ph_e;

    // Phase that follows a completed phase.
    function automatic ph_e ph_after(input ph_e p);
        case (p)
            PH_RISE: ph_after = PH_TOP;
            PH_TOP:  ph_after = PH_FALL;
            default: ph_after = PH_RISE;
        endcase
    endfunction

    // Second difference of the weight curve inside a phase.
    function automatic logic signed [2:0] curve_step(input ph_e p);
        case (p)
            PH_TOP:  curve_step = -3'sd2;
            default: curve_step = 3'sd1;
        endcase
    endfunction

    // Phase held by a lane after restart, so that the lanes' windows are N bits apart.
    function automatic ph_e lane_start_ph(input int lane);
        case (lane)
            0:       lane_start_ph = PH_RISE;
            1:       lane_start_ph = PH_FALL;
            default: lane_start_ph = PH_TOP;
        endcase
    endfunction

endpackage

// File: rtl/sinc3_seq.sv
// Sequencer for the decimator. It latches the ratio during restart, clamping it
// to 1..RATIO_MAX, counts the accepted bits inside each period of N, and flags
// the edge on which a period ends.
// Assumes: restart outranks bit_vld.
module sinc3_seq #(
    parameter int RATIO_MAX = 10000,
    parameter int RATIO_W   = $clog2(RATIO_MAX + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic [RATIO_W-1:0] ratio,
    input  logic               bit_vld,
    output logic               take,
    output logic               wrap
);
    localparam logic [RATIO_W-1:0] RMAX = RATIO_W'(RATIO_MAX);
    localparam logic [RATIO_W-1:0] ONE  = RATIO_W'(1);

    logic [RATIO_W-1:0] ratio_q;
    logic [RATIO_W-1:0] ratio_lim;
    logic [RATIO_W-1:0] pos;

    // Clamp the requested ratio into the supported range.
    always_comb begin
        if (ratio == '0)
            ratio_lim = ONE;
        else if (ratio > RMAX)
            ratio_lim = RMAX;
        else
            ratio_lim = ratio;
    end

    assign take = bit_vld & ~restart;
    assign wrap = take && (pos == ratio_q - ONE);

    // Latch the ratio on restart and step the position inside the period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ratio_q <= ONE;
            pos     <= '0;
        end else if (restart) begin
            ratio_q <= ratio_lim;
            pos     <= '0;
        end else if (take) begin
            pos <= wrap ? '0 : pos + ONE;
        end
    end

    AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pos < ratio_q);                                          // R2
    AST_RATIO_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_q >= ONE) && (ratio_q <= RMAX));                  // R7
    AST_RATIO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> $stable(ratio_q));                          // R6

endmodule

// File: rtl/sinc3_lane.sv
// One accumulator lane. It runs a 3N-bit window and builds the cubed-boxcar
// weights from two running differences: the slope d1 and the weight w.
// At the last bit of its falling phase it hands out its sum and opens a new window.
// Assumes: wrap is asserted only together with take. A lane that starts idle
// holds zero until its first window opens.
module sinc3_lane
    import sinc3_pkg::*;
#(
    parameter int LANE  = 0,
    parameter int ACC_W = 44,
    parameter int W_W   = 29,
    parameter int D_W   = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    restart,
    input  logic                    take,
    input  logic                    wrap,
    input  logic                    bit_in,
    output logic                    dump,
    output logic signed [ACC_W-1:0] dump_val
);
    localparam ph_e START_PH   = lane_start_ph(LANE);
    localparam logic START_IDLE = (LANE != 0);

    ph_e                    ph, ph_nx;
    logic                   idle;
    logic signed [W_W-1:0]  w, w_nx;
    logic signed [D_W-1:0]  d1, d1_nx;
    logic signed [ACC_W-1:0] acc, term, sum;

    // Signed contribution of the current bit, and the weight of the next bit.
    always_comb begin
        ph_nx = wrap ? ph_after(ph) : ph;
        d1_nx = d1 + D_W'(curve_step(ph_nx));
        w_nx  = w + W_W'(d1_nx);
        if (idle)
            term = '0;
        else if (bit_in)
            term = ACC_W'(w);
        else
            term = -ACC_W'(w);
        sum = acc + term;
    end

    assign dump     = wrap && (ph == PH_FALL);
    assign dump_val = sum;

    // Step the window state once per accepted bit.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            ph   <= START_PH;
            idle <= START_IDLE;
            w    <= W_W'(1);
            d1   <= D_W'(1);
            acc  <= '0;
        end else if (take) begin
            if (dump) begin
                ph   <= PH_RISE;
                idle <= 1'b0;
                w    <= W_W'(1);
                d1   <= D_W'(1);
                acc  <= '0;
            end else begin
                ph  <= ph_nx;
                acc <= sum;
                if (!idle) begin
                    w  <= w_nx;
                    d1 <= d1_nx;
                end
            end
        end
    end

    AST_IDLE_ACC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (acc == '0));                                   // R4
    AST_WEIGHT_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |-> !w[W_W-1]);                                    // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !idle) |-> !((acc[ACC_W-1] == term[ACC_W-1]) &&
                              (sum[ACC_W-1] != acc[ACC_W-1])));  // R9

endmodule

// File: rtl/sinc3_emit.sv
// Output stage. It takes the sum from whichever lane closed its window,
// registers it with a one-cycle valid pulse, and flags samples from the third
// one after a restart onward as settled.
// Assumes: at most one lane dumps per cycle.
module sinc3_emit #(
    parameter int ACC_W = 44,
    parameter int LANES = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    restart,
    input  logic [LANES-1:0]        dump,
    input  logic signed [ACC_W-1:0] dump_val [LANES],
    output logic signed [ACC_W-1:0] smp_out,
    output logic                    smp_valid,
    output logic                    smp_settled
);
    logic signed [ACC_W-1:0] pick;
    logic [1:0]              seen;

    // Select the value of the lane that is dumping.
    always_comb begin
        pick = '0;
        for (int i = 0; i < LANES; i++) begin
            if (dump[i])
                pick = pick | dump_val[i];
        end
    end

    // Register the sample and count outputs since the restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            smp_out     <= '0;
            smp_valid   <= 1'b0;
            smp_settled <= 1'b0;
            seen        <= 2'd0;
        end else begin
            smp_valid <= |dump;
            if (|dump) begin
                smp_out     <= pick;
                smp_settled <= (seen == 2'd2);
                if (seen != 2'd2)
                    seen <= seen + 2'd1;
            end
        end
    end

    AST_SINGLE_DUMP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dump));                                         // R2
    AST_UNSETTLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !smp_settled) |-> (smp_out == '0));        // R4
    AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !smp_valid);                                 // R8

endmodule

// File: rtl/bitstream_sinc3_decim.sv
// Top of the bitstream decimator. It holds a sequencer, three lanes whose
// windows are staggered by N bits, and the output stage.
// Assumes: the input comes from a single-bit modulator and has one bit per
// strobe. N changes only through restart.
module bitstream_sinc3_decim #(
    parameter  int RATIO_MAX = 10000,
    localparam int RATIO_W   = $clog2(RATIO_MAX + 1),
    localparam int ACC_W     = 2 + 3 * $clog2(RATIO_MAX)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    restart,
    input  logic [RATIO_W-1:0]      ratio,
    input  logic                    bit_in,
    input  logic                    bit_vld,
    output logic signed [ACC_W-1:0] smp_out,
    output logic                    smp_valid,
    output logic                    smp_settled
);
    localparam int LG    = $clog2(RATIO_MAX);
    localparam int W_W   = 2 * LG + 1;
    localparam int D_W   = LG + 2;
    localparam int LANES = 3;

    logic                    take, wrap;
    logic [LANES-1:0]        dump;
    logic signed [ACC_W-1:0] dump_val [LANES];

    sinc3_seq #(
        .RATIO_MAX (RATIO_MAX),
        .RATIO_W   (RATIO_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .ratio   (ratio),
        .bit_vld (bit_vld),
        .take    (take),
        .wrap    (wrap)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        sinc3_lane #(
            .LANE  (l),
            .ACC_W (ACC_W),
            .W_W   (W_W),
            .D_W   (D_W)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .restart  (restart),
            .take     (take),
            .wrap     (wrap),
            .bit_in   (bit_in),
            .dump     (dump[l]),
            .dump_val (dump_val[l])
        );
    end

    sinc3_emit #(
        .ACC_W (ACC_W),
        .LANES (LANES)
    ) u_emit (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (restart),
        .dump        (dump),
        .dump_val    (dump_val),
        .smp_out     (smp_out),
        .smp_valid   (smp_valid),
        .smp_settled (smp_settled)
    );

    AST_VALID_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> $past(take));                              // R2
    AST_DUMP_NEEDS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (|dump) |-> (wrap && !restart));                         // R8

endmodule

// File: tb/tb_bitstream_sinc3_decim.sv
`timescale 1ns/1ps
// Scoreboard bench. The driver streams bits and, at every N-th accepted bit,
// pushes the expected sample, computed from the bit history and the weight
// table. The monitor pops an entry and compares it on each output pulse.
module tb_bitstream_sinc3_decim;
    localparam int RM = 10000;
    localparam int RW = $clog2(RM + 1);
    localparam int AW = 2 + 3 * $clog2(RM);

    logic clk = 1'b0;
    logic rst_n, restart, bit_in, bit_vld;
    logic [RW-1:0] ratio;
    logic signed [AW-1:0] smp_out;
    logic smp_valid, smp_settled;

    always #10 clk = ~clk;

    bitstream_sinc3_decim #(.RATIO_MAX(RM)) dut (
        .clk(clk), .rst_n(rst_n), .restart(restart), .ratio(ratio),
        .bit_in(bit_in), .bit_vld(bit_vld),
        .smp_out(smp_out), .smp_valid(smp_valid), .smp_settled(smp_settled)
    );

    typedef struct {
        longint v;
        bit     s;
        string  tag;
    } exp_t;

    exp_t   sb[$];
    int     n_cmp = 0;
    int     n_bad = 0;
    bit     hist [0:4095];
    int     hcnt;
    int     cur_n;
    bit     const_mode;
    longint hh [0:191];

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Weight table: number of ways to write k as a sum of three values in 0..n-1.
    task automatic build_h(input int n);
        for (int k = 0; k < 192; k++) hh[k] = 0;
        for (int a = 0; a < n; a++)
            for (int b = 0; b < n; b++)
                for (int c = 0; c < n; c++)
                    hh[a + b + c] = hh[a + b + c] + 1;
    endtask

    task automatic push_exp(input int m, input string tag);
        exp_t   e;
        longint acc;
        e.tag = tag;
        if (m < 2) begin
            e.v = 0;
            e.s = 1'b0;
        end else begin
            e.s = 1'b1;
            if (const_mode) begin
                acc = longint'(cur_n) * cur_n * cur_n;
                e.v = hist[0] ? acc : -acc;
            end else begin
                acc = 0;
                for (int j = 0; j < 3 * cur_n; j++)
                    acc += hist[(m - 2) * cur_n + j] ? hh[j] : -hh[j];
                e.v = acc;
            end
        end
        sb.push_back(e);
    endtask

    // Restart with a new ratio. A bit is offered in the same cycle and must be ignored (R8).
    task automatic start_seg(input int ratio_val, input int model_n, input bit cm);
        @(negedge clk);
        restart = 1'b1;
        ratio   = RW'(ratio_val);
        bit_vld = 1'b1;
        bit_in  = 1'($urandom);
        @(negedge clk);
        restart = 1'b0;
        bit_vld = 1'b0;
        hcnt = 0;
        cur_n = model_n;
        const_mode = cm;
        if (!cm) build_h(model_n);
        check(!smp_valid && !smp_settled && smp_out == 0, "R1",
              "state after restart", longint'(smp_out), 0);
    endtask

    task automatic send(input bit b, input int gap, input string tag);
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            bit_vld = 1'b0;
            bit_in  = ~b;
        end
        @(negedge clk);
        bit_vld = 1'b1;
        bit_in  = b;
        if (hcnt < 4096) hist[hcnt] = b;
        hcnt++;
        if (hcnt % cur_n == 0) push_exp(hcnt / cur_n - 1, tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bit_vld = 1'b0;
        end
    endtask

    // Monitor: compare each output pulse against the oldest expected entry.
    always @(negedge clk) begin
        if (rst_n && smp_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R2", "unexpected output pulse", longint'(smp_out), 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(longint'(smp_out) == e.v, e.tag, "sample value", longint'(smp_out), e.v);
                check(smp_settled == e.s, "R4", "settled flag", longint'(smp_settled), longint'(e.s));
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog expired: actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; restart = 1'b0; bit_vld = 1'b0; bit_in = 1'b0; ratio = RW'(4);
        repeat (3) @(negedge clk);
        check(!smp_valid && !smp_settled && smp_out == 0, "R1",
              "state in reset", longint'(smp_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!smp_valid && !smp_settled && smp_out == 0, "R1",
              "state after reset", longint'(smp_out), 0);

        // R3: random stream, N=4, bits back to back.
        start_seg(4, 4, 1'b0);
        for (int i = 0; i < 40; i++) send(1'($urandom), 0, "R3");

        // R3: N=1, one lane closes a window and opens the next on the same edge.
        start_seg(1, 1, 1'b0);
        for (int i = 0; i < 12; i++) send(1'($urandom), 0, "R3");

        // R5: gaps with a bit_in value the design must ignore.
        start_seg(5, 5, 1'b0);
        for (int i = 0; i < 50; i++) send(1'($urandom), $urandom_range(0, 3), "R5");

        // R6: the ratio port changes without a restart.
        start_seg(4, 4, 1'b0);
        for (int i = 0; i < 12; i++) send(1'($urandom), 0, "R6");
        ratio = RW'(9);
        for (int i = 0; i < 28; i++) send(1'($urandom), 1, "R6");

        // R7: a ratio of 0 is used as 1.
        start_seg(0, 1, 1'b0);
        for (int i = 0; i < 10; i++) send(1'($urandom), 0, "R7");

        // R8: restart coincides with the bit that would finish a window.
        start_seg(3, 3, 1'b0);
        for (int i = 0; i < 11; i++) send(1'($urandom), 0, "R8");
        start_seg(16, 16, 1'b0);
        idle(3);
        check(sb.size() == 0, "R8", "pending samples after restart", sb.size(), 0);

        // R3: N=16, alternating bits.
        for (int i = 0; i < 96; i++) send(1'(i % 2), 0, "R3");

        // R7 and R9: an oversized ratio is clamped to the maximum; all ones give +N^3.
        start_seg(16383, RM, 1'b1);
        for (int i = 0; i < 3 * RM; i++) send(1'b1, 0, "R9");

        // R9: all zeros at the maximum ratio give -N^3.
        start_seg(RM, RM, 1'b1);
        for (int i = 0; i < 3 * RM; i++) send(1'b0, 0, "R9");

        idle(5);
        check(sb.size() == 0, "R2", "expected samples never produced", sb.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule